// File: doc/BRIEF.md
# Accumulator Readout Rounding and Saturation Unit

This block conditions a multiply-accumulate accumulator value. An operation arrives as one stream beat: a 64-bit value, an operation code, an accumulator index and three mode bits. The unit does one of three things with it. It can convert the value to a 32-bit register word in fractional, signed integer or unsigned integer form. It can clamp the value before it is written back into an accumulator. It can scale a raw fractional product. Rounding is round-half-to-even at one of two bit positions. Saturation widths depend on the mode.

The unit holds a global overflow flag and one sticky overflow flag for each accumulator. Only the store-back saturation operations set these flags. Once the global flag is set, it changes how later store-back operations clamp. Both kinds of flag stay set until the plain clear input is asserted.

The input side is a valid/ready stream. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on `out_data`, with `out_valid` high, from the next edge on. `in_ready` is high when the output register is empty or is being drained in the same cycle, so back-pressure passes through in one cycle. `out_data` is held stable while `out_valid` is high and `out_ready` is low.

Top module: `mac_acc_conditioner`

## Requirements
- R1: A beat taken at an edge yields `out_valid` high from the next edge. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. `in_ready` equals (not `out_valid`) or `out_ready`. Operation codes 6 and 7 return the input value unchanged.
- R2: Operation 0 (fractional readout) with `mode_frac16` set: the value is shifted arithmetically right by 24, and bits 23:0 act as the remainder. The result is incremented when the remainder exceeds 0x800000, and incremented by its own LSB when the remainder equals 0x800000. The low 16 bits are returned, zero-extended.
- R3: Operation 0 with `mode_frac16` clear and `mode_round` set: the value is shifted arithmetically right by 8, with the same half-to-even rule around 0x80 on bits 7:0. The low 32 bits are returned.
- R4: Operation 0 with both `mode_frac16` and `mode_round` clear: the value is shifted arithmetically right by 8, and the low 8 bits are discarded.
- R5: Operation 0 with `mode_sat` set: a rounded value outside the signed 16-bit range (16-bit mode) or the signed 32-bit range is replaced. A positive value becomes 0x7FFF or 0x7FFFFFFF. A negative value becomes 0x8000 or 0x80000000. Without `mode_sat`, the value is truncated.
- R6: Operation 1 (signed integer readout) returns bits 31:0 when the value fits in a signed 32-bit range. Otherwise it returns 0x80000000 for a negative value and 0x7FFFFFFF for a positive one.
- R7: Operation 2 (unsigned integer readout) returns 0xFFFFFFFF when any bit above bit 31 is set, and bits 31:0 otherwise.
- R8: Operation 3 (signed store-back) sign-extends the value from bit 47. Overflow means bits 63:47 are not all equal. The global flag becomes old-flag OR overflow. If the global flag is now set, the selected sticky flag is set. In that case, with `mode_sat` set, the result becomes 0x7FFFFFFF, or 0xFFFFFFFF80000000 when bit 47 is set.
- R9: Operation 4 (unsigned store-back): overflow means any of bits 63:47... more precisely, any of bits 63:48 set. The flags are updated as in R8. If the global flag is set, then with `mode_sat` the result is 0 when the value exceeds 2^53 and 2^48-1 otherwise. Without `mode_sat`, the value is masked to 48 bits. If the global flag is clear, the value passes unchanged.
- R10: Operation 5 (fractional product scaling) shifts the value logically right by 24. With `mode_round` set, it applies the half-to-even rule on bits 23:0.
- R11: `ovf_flag` and `acc_ovf` never clear except on an edge where `flag_clr` is high. At such an edge, clear takes priority over any flag set in the same cycle. Operations 0, 1, 2, 5, 6 and 7 leave the flags unchanged.
- R12: After reset, `out_valid`, `ovf_flag` and `acc_ovf` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can take a beat |
| in_data | input | 64 | Accumulator or product value |
| in_op | input | 3 | Operation code (0..7, see requirements) |
| in_acc_sel | input | 2 | Accumulator index for the sticky flag |
| mode_frac16 | input | 1 | 16-bit fractional result mode |
| mode_round | input | 1 | Rounding enable |
| mode_sat | input | 1 | Overflow saturation enable |
| flag_clr | input | 1 | Clears all overflow flags |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result (readouts zero-extended from 32 bits) |
| ovf_flag | output | 1 | Global overflow flag |
| acc_ovf | output | 4 | Sticky overflow flag per accumulator |

## Verification
The hardest case to reach is a store-back that clamps even though its own value is in range. This happens because an earlier overflow left the global flag set, which also marks a second accumulator's sticky flag. The stimulus reaches it by sending a deliberate 48-bit overflow, then an in-range store-back to another index with saturation enabled. It also asserts the clear in the same cycle as an overflowing store-back. Exact-tie remainders at both rounding positions, with odd and even quotients, are built directly into the directed values and the random mix. The output side is stalled at random so that held results are compared as well.

// File: rtl/mac_cond_pkg.sv
package mac_cond_pkg;
  typedef enum logic [2:0] {
    OP_RD_FRAC  = 3'd0,
    OP_RD_SINT  = 3'd1,
    OP_RD_UINT  = 3'd2,
    OP_SAT_SINT = 3'd3,
    OP_SAT_UINT = 3'd4,
    OP_MUL_FRAC = 3'd5,
    OP_PASS_A   = 3'd6,
    OP_PASS_B   = 3'd7
  } mac_op_e;
endpackage

// File: rtl/mac_half_even_shift.sv
module mac_half_even_shift #(
  parameter int DATA_W = 64,
  parameter int SHIFT  = 8,
  parameter bit ARITH  = 1'b1
) (
  input  logic [DATA_W-1:0] val,
  input  logic              en,
  output logic [DATA_W-1:0] res
);
  localparam logic [SHIFT-1:0] HALF = {1'b1, {(SHIFT-1){1'b0}}};

  logic [DATA_W-1:0] shifted;
  logic [SHIFT-1:0]  rem;
  logic              inc;

  generate
    if (ARITH) begin : g_arith
      assign shifted = DATA_W'($signed(val) >>> SHIFT);
    end else begin : g_logic
      assign shifted = val >> SHIFT;
    end
  endgenerate

  assign rem = val[SHIFT-1:0];
  assign inc = en & ((rem > HALF) | ((rem == HALF) & shifted[0]));
  assign res = shifted + {{(DATA_W-1){1'b0}}, inc};
endmodule

// File: rtl/mac_readout.sv
module mac_readout import mac_cond_pkg::*; #(
  parameter int DATA_W       = 64,
  parameter int WORD_W       = 32,
  parameter int HALF_W       = 16,
  parameter int FINE_SHIFT   = 8,
  parameter int COARSE_SHIFT = 24
) (
  input  logic [DATA_W-1:0] val,
  input  mac_op_e           op,
  input  logic              frac16,
  input  logic              rnd,
  input  logic              sat,
  output logic [WORD_W-1:0] word
);
  localparam logic [WORD_W-1:0] W_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] W_MIN = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] H_MAX = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] H_MIN = {1'b1, {(HALF_W-1){1'b0}}};

  logic [DATA_W-1:0] r_coarse, r_fine, fr;
  logic fits_h, fits_w, sint_fits;
  logic [WORD_W-1:0] frac_word, sint_word, uint_word;

  mac_half_even_shift #(.DATA_W(DATA_W), .SHIFT(COARSE_SHIFT), .ARITH(1'b1)) u_coarse (
    .val(val), .en(1'b1), .res(r_coarse));
  mac_half_even_shift #(.DATA_W(DATA_W), .SHIFT(FINE_SHIFT), .ARITH(1'b1)) u_fine (
    .val(val), .en(rnd), .res(r_fine));

  assign fr     = frac16 ? r_coarse : r_fine;
  assign fits_h = (&fr[DATA_W-1:HALF_W-1]) | ~(|fr[DATA_W-1:HALF_W-1]);
  assign fits_w = (&fr[DATA_W-1:WORD_W-1]) | ~(|fr[DATA_W-1:WORD_W-1]);

  always_comb begin
    if (frac16) begin
      if (sat && !fits_h) frac_word = {{(WORD_W-HALF_W){1'b0}}, (fr[DATA_W-1] ? H_MIN : H_MAX)};
      else                frac_word = {{(WORD_W-HALF_W){1'b0}}, fr[HALF_W-1:0]};
    end else begin
      if (sat && !fits_w) frac_word = fr[DATA_W-1] ? W_MIN : W_MAX;
      else                frac_word = fr[WORD_W-1:0];
    end
  end

  assign sint_fits = (&val[DATA_W-1:WORD_W-1]) | ~(|val[DATA_W-1:WORD_W-1]);
  assign sint_word = sint_fits ? val[WORD_W-1:0] : (val[DATA_W-1] ? W_MIN : W_MAX);
  assign uint_word = (|val[DATA_W-1:WORD_W]) ? {WORD_W{1'b1}} : val[WORD_W-1:0];

  always_comb begin
    case (op)
      OP_RD_FRAC: word = frac_word;
      OP_RD_SINT: word = sint_word;
      OP_RD_UINT: word = uint_word;
      default:    word = '0;
    endcase
  end
endmodule

// File: rtl/mac_store_sat.sv
module mac_store_sat import mac_cond_pkg::*; #(
  parameter int DATA_W   = 64,
  parameter int ACC_W    = 48,
  parameter int WORD_W   = 32,
  parameter int UCLR_BIT = 53
) (
  input  logic [DATA_W-1:0] val,
  input  mac_op_e           op,
  input  logic              sat,
  input  logic              ovf_in,
  output logic [DATA_W-1:0] res,
  output logic              ovf_out,
  output logic              mark
);
  localparam logic [DATA_W-1:0] ACC_MASK = {{(DATA_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};
  localparam logic [DATA_W-1:0] UCLR_VAL = {{(DATA_W-1){1'b0}}, 1'b1} << UCLR_BIT;
  localparam logic [DATA_W-1:0] S_POS = {{(DATA_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_NEG = {{(DATA_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

  logic [DATA_W-1:0] sx;
  logic det_s, det_u, is_s, is_u, flag_now;

  assign is_s  = (op == OP_SAT_SINT);
  assign is_u  = (op == OP_SAT_UINT);
  assign sx    = {{(DATA_W-ACC_W){val[ACC_W-1]}}, val[ACC_W-1:0]};
  assign det_s = ~((&val[DATA_W-1:ACC_W-1]) | ~(|val[DATA_W-1:ACC_W-1]));
  assign det_u = |val[DATA_W-1:ACC_W];

  assign flag_now = ovf_in | (is_s & det_s) | (is_u & det_u);
  assign ovf_out  = flag_now;
  assign mark     = (is_s | is_u) & flag_now;

  always_comb begin
    res = val;
    if (is_s) begin
      res = sx;
      if (flag_now && sat) res = sx[DATA_W-1] ? S_NEG : S_POS;
    end else if (is_u && flag_now) begin
      if (sat) res = (val > UCLR_VAL) ? '0 : ACC_MASK;
      else     res = val & ACC_MASK;
    end
  end
endmodule

// File: rtl/mac_acc_conditioner.sv
module mac_acc_conditioner import mac_cond_pkg::*; #(
  parameter int DATA_W   = 64,
  parameter int ACC_W    = 48,
  parameter int WORD_W   = 32,
  parameter int HALF_W   = 16,
  parameter int GUARD_W  = 8,
  parameter int NUM_ACC  = 4,
  parameter int UCLR_BIT = 53
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_data,
  input  logic [2:0]                 in_op,
  input  logic [$clog2(NUM_ACC)-1:0] in_acc_sel,
  input  logic                       mode_frac16,
  input  logic                       mode_round,
  input  logic                       mode_sat,
  input  logic                       flag_clr,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DATA_W-1:0]          out_data,
  output logic                       ovf_flag,
  output logic [NUM_ACC-1:0]         acc_ovf
);
  localparam int FINE_SHIFT   = ACC_W - WORD_W - GUARD_W;
  localparam int COARSE_SHIFT = FINE_SHIFT + HALF_W;
  localparam int SEL_W        = $clog2(NUM_ACC);

  mac_op_e           op;
  logic              fire, ovf_nx, mark;
  logic [WORD_W-1:0] rd_word;
  logic [DATA_W-1:0] sat_res, mul_res, nxt;

  assign op       = mac_op_e'(in_op);
  assign in_ready = ~out_valid | out_ready;
  assign fire     = in_valid & in_ready;

  mac_readout #(.DATA_W(DATA_W), .WORD_W(WORD_W), .HALF_W(HALF_W),
                .FINE_SHIFT(FINE_SHIFT), .COARSE_SHIFT(COARSE_SHIFT)) u_rd (
    .val(in_data), .op(op), .frac16(mode_frac16), .rnd(mode_round),
    .sat(mode_sat), .word(rd_word));

  mac_store_sat #(.DATA_W(DATA_W), .ACC_W(ACC_W), .WORD_W(WORD_W),
                  .UCLR_BIT(UCLR_BIT)) u_sat (
    .val(in_data), .op(op), .sat(mode_sat), .ovf_in(ovf_flag),
    .res(sat_res), .ovf_out(ovf_nx), .mark(mark));

  mac_half_even_shift #(.DATA_W(DATA_W), .SHIFT(COARSE_SHIFT), .ARITH(1'b0)) u_mul (
    .val(in_data), .en(mode_round), .res(mul_res));

  always_comb begin
    case (op)
      OP_RD_FRAC, OP_RD_SINT, OP_RD_UINT: nxt = {{(DATA_W-WORD_W){1'b0}}, rd_word};
      OP_SAT_SINT, OP_SAT_UINT:           nxt = sat_res;
      OP_MUL_FRAC:                        nxt = mul_res;
      default:                            nxt = in_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire | (out_valid & ~out_ready);
      if (fire) out_data <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (flag_clr) ovf_flag <= 1'b0;
    else if (fire)     ovf_flag <= ovf_nx;
  end

  generate
    for (genvar g = 0; g < NUM_ACC; g++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        acc_ovf[g] <= 1'b0;
        else if (flag_clr) acc_ovf[g] <= 1'b0;
        else if (fire && mark && in_acc_sel == SEL_W'(g)) acc_ovf[g] <= 1'b1;
      end
    end
  endgenerate

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((acc_ovf & $past(acc_ovf)) == $past(acc_ovf)) && (ovf_flag || !$past(ovf_flag)));
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (acc_ovf == '0) && !ovf_flag);
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !flag_clr && in_op != 3'd3 && in_op != 3'd4
      |=> $stable(acc_ovf) && $stable(ovf_flag));
  a_r7_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 3'd2 && (|in_data[DATA_W-1:WORD_W])
      |=> out_data == {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}});
  a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 3'd4 && mode_sat && (ovf_flag || (|in_data[DATA_W-1:ACC_W]))
      |=> out_data == '0 || out_data == {{(DATA_W-ACC_W){1'b0}}, {ACC_W{1'b1}}});
endmodule

// File: tb/mac_acc_conditioner_test.sv
module mac_acc_conditioner_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, in_ready, mode_frac16, mode_round, mode_sat, flag_clr;
  logic out_valid, out_ready, ovf_flag;
  logic [63:0] in_data, out_data;
  logic [2:0] in_op;
  logic [1:0] in_acc_sel;
  logic [3:0] acc_ovf;

  mac_acc_conditioner uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_op(in_op), .in_acc_sel(in_acc_sel),
    .mode_frac16(mode_frac16), .mode_round(mode_round), .mode_sat(mode_sat),
    .flag_clr(flag_clr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .ovf_flag(ovf_flag), .acc_ovf(acc_ovf));

  int total = 0;
  int bad = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];
  bit m_ovf = 1'b0;
  bit [3:0] m_pav = 4'd0;
  bit mon_on = 1'b0;
  bit stall_mode = 1'b0;
  bit [63:0] rs = 64'h9E3779B97F4A7C15;

  localparam longint S32MAX = 64'sh000000007FFFFFFF;
  localparam longint S32MIN = 64'shFFFFFFFF80000000;

  function bit [63:0] nxt_rand();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  function automatic logic [63:0] rne(logic [63:0] x, int s, bit arith);
    logic [63:0] q, r, h;
    if (arith) q = $signed(x) >>> s;
    else       q = x >> s;
    h = 64'd1 << (s - 1);
    r = x & ((64'd1 << s) - 64'd1);
    if (r > h) q = q + 64'd1;
    else if (r == h) q = q + {63'd0, q[0]};
    return q;
  endfunction

  task automatic model(input logic [2:0] op, input bit half, input bit rnd, input bit sat,
                       input logic [1:0] sel, input logic [63:0] v,
                       output logic [63:0] e, output string tag);
    logic [63:0] t;
    longint st, sx;
    bit ov;
    case (op)
      3'd0: begin
        if (half) t = rne(v, 24, 1'b1);
        else if (rnd) t = rne(v, 8, 1'b1);
        else t = $signed(v) >>> 8;
        st = $signed(t);
        tag = half ? "R2" : (rnd ? "R3" : "R4");
        if (half) begin
          if (sat && (st > 32767 || st < -32768)) begin
            e = (st < 0) ? 64'h8000 : 64'h7FFF; tag = "R5";
          end else e = {48'd0, t[15:0]};
        end else begin
          if (sat && (st > S32MAX || st < S32MIN)) begin
            e = (st < 0) ? 64'h80000000 : 64'h7FFFFFFF; tag = "R5";
          end else e = {32'd0, t[31:0]};
        end
      end
      3'd1: begin
        st = $signed(v); tag = "R6";
        if (st <= S32MAX && st >= S32MIN) e = {32'd0, v[31:0]};
        else e = (st < 0) ? 64'h80000000 : 64'h7FFFFFFF;
      end
      3'd2: begin
        tag = "R7";
        e = (v > 64'hFFFFFFFF) ? 64'hFFFFFFFF : v;
      end
      3'd3: begin
        tag = "R8";
        sx = $signed(v << 16) >>> 16;
        ov = (sx != $signed(v));
        m_ovf = m_ovf | ov;
        if (m_ovf) begin
          m_pav[sel] = 1'b1;
          if (sat) sx = (sx < 0) ? 64'shFFFFFFFF80000000 : 64'sh7FFFFFFF;
        end
        e = sx;
      end
      3'd4: begin
        tag = "R9";
        ov = (v >= 64'h0001_0000_0000_0000);
        m_ovf = m_ovf | ov;
        e = v;
        if (m_ovf) begin
          m_pav[sel] = 1'b1;
          if (sat) e = (v > 64'h0020_0000_0000_0000) ? 64'd0 : 64'h0000_FFFF_FFFF_FFFF;
          else     e = v % 64'h0001_0000_0000_0000;
        end
      end
      3'd5: begin
        tag = "R10";
        e = rnd ? rne(v, 24, 1'b0) : (v >> 24);
      end
      default: begin
        tag = "R1";
        e = v;
      end
    endcase
  endtask

  always @(negedge clk) begin
    logic [63:0] e;
    string tg;
    #5;
    if (mon_on) begin
      total++;
      if ({ovf_flag, acc_ovf} !== {m_ovf, m_pav}) begin
        bad++;
        $display("FAIL R11 flags got=%b exp=%b", {ovf_flag, acc_ovf}, {m_ovf, m_pav});
      end
      total++;
      if (out_valid !== (exp_q.size() != 0)) begin
        bad++;
        $display("FAIL R1 out_valid got=%b exp=%b", out_valid, exp_q.size() != 0);
      end
      total++;
      if (in_ready !== (exp_q.size() == 0 || out_ready)) begin
        bad++;
        $display("FAIL R1 in_ready got=%b exp=%b", in_ready, exp_q.size() == 0 || out_ready);
      end
      if (out_valid && out_ready && exp_q.size() > 0) begin
        total++;
        if (out_data !== exp_q[0]) begin
          bad++;
          $display("FAIL %s out_data got=%h exp=%h", tag_q[0], out_data, exp_q[0]);
        end
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (in_valid && in_ready) begin
        model(in_op, mode_frac16, mode_round, mode_sat, in_acc_sel, in_data, e, tg);
        exp_q.push_back(e);
        tag_q.push_back(tg);
      end
      if (flag_clr) begin
        m_ovf = 1'b0;
        m_pav = 4'd0;
      end
    end
  end

  task automatic send(input logic [2:0] op, input bit half, input bit rnd, input bit sat,
                      input logic [1:0] sel, input logic [63:0] d, input bit clr);
    bit acc;
    bit [63:0] r;
    in_op = op; mode_frac16 = half; mode_round = rnd; mode_sat = sat;
    in_acc_sel = sel; in_data = d; in_valid = 1'b1; flag_clr = clr;
    r = nxt_rand();
    out_ready = stall_mode ? r[5] : 1'b1;
    do begin
      #6;
      acc = in_ready;
      @(negedge clk);
      flag_clr = 1'b0;
      if (!acc) begin
        r = nxt_rand();
        out_ready = stall_mode ? r[9] : 1'b1;
      end
    end while (!acc);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    in_valid = 1'b0;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL R1 watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [63:0] r, d, v;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; flag_clr = 1'b0;
    in_data = '0; in_op = '0; in_acc_sel = '0;
    mode_frac16 = 1'b0; mode_round = 1'b0; mode_sat = 1'b0;
    repeat (3) @(negedge clk);
    #5;
    total++;
    if (out_valid !== 1'b0 || ovf_flag !== 1'b0 || acc_ovf !== 4'd0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R12 reset got=%b%b%b%b exp=0000001", out_valid, ovf_flag, acc_ovf, in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);

    // R2 ties with even and odd quotient, above half
    send(3'd0, 1, 0, 0, 0, 64'h0000_0001_0080_0000, 0);
    send(3'd0, 1, 0, 0, 0, 64'h0000_0001_0180_0000, 0);
    send(3'd0, 1, 0, 0, 0, 64'h0000_0000_0280_0001, 0);
    // R3 ties and above half
    send(3'd0, 0, 1, 0, 0, 64'h180, 0);
    send(3'd0, 0, 1, 0, 0, 64'h280, 0);
    send(3'd0, 0, 1, 0, 0, 64'h281, 0);
    // R4 plain discard on a negative value
    send(3'd0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FF00, 0);
    send(3'd0, 0, 0, 0, 0, 64'h0000_0000_1234_56FF, 0);
    // R5 saturation both widths, and truncation without it
    send(3'd0, 1, 0, 1, 0, 64'h0000_7FFF_FFFF_FFFF, 0);
    send(3'd0, 1, 0, 1, 0, 64'hFFFF_8000_0000_0000, 0);
    send(3'd0, 0, 0, 1, 0, 64'h0000_0100_0000_0000, 0);
    send(3'd0, 0, 1, 1, 0, 64'hFFFF_FE00_0000_0000, 0);
    send(3'd0, 0, 0, 0, 0, 64'h0000_0100_0000_0000, 0);
    // R6 boundaries
    send(3'd1, 0, 0, 0, 0, 64'h0000_0000_7FFF_FFFF, 0);
    send(3'd1, 0, 0, 0, 0, 64'h0000_0000_8000_0000, 0);
    send(3'd1, 0, 0, 0, 0, 64'hFFFF_FFFF_7FFF_FFFF, 0);
    send(3'd1, 0, 0, 0, 0, 64'hFFFF_FFFF_8000_0000, 0);
    // R7 boundaries
    send(3'd2, 0, 0, 0, 0, 64'h0000_0001_0000_0000, 0);
    send(3'd2, 0, 0, 0, 0, 64'h0000_0000_FFFF_FFFF, 0);
    // R8: in range, overflow, then sticky clamp of an in-range value
    send(3'd3, 0, 0, 1, 0, 64'h0000_7FFF_FFFF_FFFF, 0);
    send(3'd3, 0, 0, 1, 2, 64'h0000_8000_0000_0000, 0);
    send(3'd3, 0, 0, 1, 1, 64'h0000_0000_0000_1234, 0);
    send(3'd2, 0, 0, 0, 3, 64'h5, 0);
    clear_flags();
    send(3'd3, 0, 0, 0, 3, 64'h0001_8000_0000_0001, 0);
    // R11: clear in the same cycle as an overflowing store-back
    send(3'd3, 0, 0, 1, 0, 64'h0010_0000_0000_0000, 1);
    idle(2);
    // R9 both saturation branches and masking
    send(3'd4, 0, 0, 1, 1, 64'h0001_0000_0000_0000, 0);
    send(3'd4, 0, 0, 1, 1, 64'h0040_0000_0000_0000, 0);
    send(3'd4, 0, 0, 0, 2, 64'h0040_0000_1234_5678, 0);
    clear_flags();
    send(3'd4, 0, 0, 1, 0, 64'h0000_FFFF_0000_0001, 0);
    // R10 product scaling
    send(3'd5, 0, 1, 0, 0, 64'h0000_0000_0180_0000, 0);
    send(3'd5, 0, 0, 0, 0, 64'h0000_0000_0180_0000, 0);
    send(3'd5, 0, 1, 0, 0, 64'hFFFF_FFFF_FF80_0001, 0);
    // R1 pass-through codes
    send(3'd6, 0, 0, 0, 0, 64'hDEAD_BEEF_0123_4567, 0);
    send(3'd7, 1, 1, 1, 0, 64'h8000_0000_0000_0001, 0);

    for (int i = 0; i < 800; i++) begin
      stall_mode = (i >= 200);
      r = nxt_rand();
      d = nxt_rand();
      case (r[2:0])
        3'd0: v = d >> 20;
        3'd1: v = {20'hFFFFF, d[43:0]};
        3'd2: v = {16'h0, d[47:24], 24'h800000};
        3'd3: v = {d[63:56] & 8'h01, d[55:8], 8'h80};
        3'd4: v = 64'h0000_7FFF_FFFF_FFF8 + {60'd0, d[3:0]};
        3'd5: v = {32'd0, d[31:0]};
        default: v = d;
      endcase
      send(r[10:8], r[11], r[12], r[13], r[15:14], v, (r[23:19] == 5'd0));
      if (r[31:27] == 5'd0) idle(1);
    end

    idle(4);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1 pending results got=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule